// File: doc/BRIEF.md
# Pointerless I2C Port Expander Target

This block is an I2C target that connects a serial two-wire bus to a single 8-bit port latch. There is no command byte and no register pointer. After the address byte, every byte the master writes goes straight to the port latch, and every byte the master reads is a fresh sample of the input pins. The block also produces one-cycle write and read strobes, which neighbouring interrupt logic can use to clear its pending state.

SCL and SDA are oversampled by the system clock through a short synchronizer. The open-drain SDA output is modelled as a drive-low enable, and the bus wiring outside the block combines it with the other drivers. The 7-bit target address is a fixed 4-bit prefix followed by three strap inputs. A parameter selects one of two prefixes. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `i2c_port_target`

## Requirements
- R1: After reset, `port_o` is 8'hFF, `sda_drive_low_o` is 0, and both strobes are 0.
- R2: The target answers only the address byte {prefix, strap_i[2], strap_i[1], strap_i[0], rw}, sent MSB first. The prefix is 4'b0100 when ALT_PREFIX=0 and 4'b0111 when ALT_PREFIX=1. rw=1 selects read. The target acknowledges by pulling SDA low through the ninth clock.
- R3: On an address mismatch the target never pulls SDA low and leaves `port_o` unchanged. It ignores all following bytes until the next START.
- R4: In a write, each data byte is acknowledged. The byte appears on `port_o` at the rising SCL edge of its acknowledge clock, in the same cycle as a one-cycle `wr_strobe_o`.
- R5: A write transfer may carry any number of data bytes. Each acknowledged byte replaces the previous value on `port_o`.
- R6: In a read, the first byte is the value of `pin_i` sampled at the SCL falling edge that ends the address acknowledge. Bytes are sent MSB first, and each sample raises `rd_strobe_o` for one cycle.
- R7: When the master acknowledges a read byte (SDA low on the ninth clock), the target sends another byte, sampled at the falling edge that ends that acknowledge. On a master NACK the target releases SDA and stays released until the next START.
- R8: A change on `pin_i` after a byte's sample point is not reflected in that byte.
- R9: A STOP in the middle of a write byte discards the partial bits, and `port_o` keeps the last acknowledged value.
- R10: A repeated START at any point restarts the address phase, and the new address selects the direction of the new transfer.
- R11: `sda_drive_low_o` changes only while SCL is low.
- R12: `wr_strobe_o` and `rd_strobe_o` last one cycle each and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Low three address bits from board straps |
| pin_i | input | 8 | Current pin levels, sampled for reads |
| port_o | output | 8 | Port latch driving the pins low where 0 |
| sda_drive_low_o | output | 1 | When 1, the target pulls SDA low |
| wr_strobe_o | output | 1 | One-cycle pulse when a write byte lands on the port |
| rd_strobe_o | output | 1 | One-cycle pulse when the pins are sampled for a read |

## Verification
Two functions can land in the same system cycle: bus-condition detection (START or STOP) and the bit engine's reaction to an SCL edge. The most delicate case is a STOP after only part of a write byte has been shifted in, while the engine is still mid-byte. The test sends four data bits, issues a STOP, and then checks that `port_o` and the write-strobe count are unchanged. A second collision is a repeated START that follows a write acknowledge and changes direction; it passes only if the read data reflects the pins and the port still holds the written byte.

// File: rtl/i2cpt_pkg.sv
package i2cpt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE, ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK
  } tgt_state_e;

  function automatic logic [3:0] addr_prefix(input bit alt);
    return alt ? 4'b0111 : 4'b0100;
  endfunction
endpackage

// File: rtl/i2cpt_line_sync.sv
module i2cpt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // bit 1 = SCL, bit 0 = SDA
  logic [1:0] chain [STAGES];
  logic [1:0] prev;
  logic [1:0] cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= 2'b11;
      prev <= 2'b11;
    end else begin
      chain[0] <= {scl_i, sda_i};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign cur       = chain[STAGES-1];
  assign sda_s     = cur[0];
  assign scl_rise  = cur[1] & ~prev[1];
  assign scl_fall  = ~cur[1] & prev[1];
  assign start_det = cur[1] & prev[1] & prev[0] & ~cur[0];
  assign stop_det  = cur[1] & prev[1] & ~prev[0] & cur[0];
endmodule

// File: rtl/i2cpt_addr_match.sv
module i2cpt_addr_match #(
  parameter bit ALT_PREFIX = 1'b0,
  parameter int ADDR_W     = 7
) (
  input  logic [2:0]        strap_i,
  input  logic [ADDR_W-1:0] rx_addr,
  output logic              hit
);
  localparam logic [3:0] PFX = i2cpt_pkg::addr_prefix(ALT_PREFIX);
  logic [ADDR_W-1:0] own;
  assign own = {PFX, strap_i};
  assign hit = (rx_addr == own);
endmodule

// File: rtl/i2cpt_engine.sv
module i2cpt_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_hit,
  input  logic [DATA_W-1:0] pin_i,
  output logic [DATA_W-2:0] rx_addr,
  output logic [DATA_W-1:0] port_q,
  output logic              drv_low,
  output logic              wr_stb,
  output logic              rd_stb
);
  import i2cpt_pkg::*;
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  tgt_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic              full;
  logic              is_rd;
  logic              ack_seen;

  assign rx_addr = sh[DATA_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; full <= 1'b0; is_rd <= 1'b0;
      ack_seen <= 1'b0; drv_low <= 1'b0; wr_stb <= 1'b0; rd_stb <= 1'b0;
      port_q <= '1;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (start_det) begin
        st <= ST_ADDR; cnt <= '0; full <= 1'b0; drv_low <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; cnt <= '0; full <= 1'b0; drv_low <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise && !full) begin
              sh <= {sh[DATA_W-2:0], sda_s};
              if (cnt == LAST) begin full <= 1'b1; cnt <= '0; end
              else cnt <= cnt + 1'b1;
            end
            if (scl_fall && full) begin
              full <= 1'b0;
              if (st == ST_ADDR) begin
                if (addr_hit) begin
                  is_rd <= sh[0]; drv_low <= 1'b1; st <= ST_ADDR_ACK;
                end else st <= ST_IDLE;
              end else begin
                drv_low <= 1'b1; st <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            cnt <= '0;
            if (is_rd) begin
              sh <= pin_i; drv_low <= ~pin_i[DATA_W-1]; rd_stb <= 1'b1;
              st <= ST_RD_BYTE;
            end else begin
              drv_low <= 1'b0; st <= ST_WR_BYTE;
            end
          end
          ST_WR_ACK: begin
            if (scl_rise) begin port_q <= sh; wr_stb <= 1'b1; end
            if (scl_fall) begin drv_low <= 1'b0; st <= ST_WR_BYTE; end
          end
          ST_RD_BYTE: if (scl_fall) begin
            if (cnt == LAST) begin
              cnt <= '0; drv_low <= 1'b0; st <= ST_RD_ACK;
            end else begin
              cnt <= cnt + 1'b1;
              sh <= {sh[DATA_W-2:0], 1'b0};
              drv_low <= ~sh[DATA_W-2];
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) ack_seen <= ~sda_s;
            if (scl_fall) begin
              if (ack_seen) begin
                sh <= pin_i; drv_low <= ~pin_i[DATA_W-1]; rd_stb <= 1'b1;
                cnt <= '0; st <= ST_RD_BYTE;
              end else st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_port_target.sv
module i2c_port_target #(
  parameter bit ALT_PREFIX  = 1'b0,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic [DATA_W-1:0] pin_i,
  output logic [DATA_W-1:0] port_o,
  output logic              sda_drive_low_o,
  output logic              wr_strobe_o,
  output logic              rd_strobe_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det, hit;
  logic [DATA_W-2:0] rx_addr;

  i2cpt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2cpt_addr_match #(.ALT_PREFIX(ALT_PREFIX), .ADDR_W(DATA_W-1)) u_match (
    .strap_i(strap_i), .rx_addr(rx_addr), .hit(hit));

  i2cpt_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_hit(hit), .pin_i(pin_i), .rx_addr(rx_addr), .port_q(port_o),
    .drv_low(sda_drive_low_o), .wr_stb(wr_strobe_o), .rd_stb(rd_strobe_o));
endmodule

// File: rtl/i2cpt_checker.sv
module i2cpt_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_drive_low_o,
  input logic              wr_strobe_o,
  input logic              rd_strobe_o,
  input logic [DATA_W-1:0] port_o
);
  assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drive_low_o) |-> !scl_i);
  assert_wr_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_o |=> !wr_strobe_o);
  assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    rd_strobe_o |=> !rd_strobe_o);
  assert_strobes_apart_R12: assert property (@(posedge clk) disable iff (rst)
    !(wr_strobe_o && rd_strobe_o));
  assert_port_only_on_write_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(port_o) |-> wr_strobe_o);
  assert_write_on_high_R4: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_o |-> scl_i);
  assert_sample_on_low_R6: assert property (@(posedge clk) disable iff (rst)
    rd_strobe_o |-> !scl_i);
endmodule

bind i2c_port_target i2cpt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_drive_low_o(sda_drive_low_o),
  .wr_strobe_o(wr_strobe_o), .rd_strobe_o(rd_strobe_o), .port_o(port_o));

// File: tb/sim_i2c_port_target.sv
`timescale 1ns/1ps
module sim_i2c_port_target;
  localparam int Q = 5;
  logic clk = 0, rst = 1, scl = 1, sda_m = 1;
  logic [2:0] strap = 3'b101;
  logic [7:0] pins = 8'hFF;
  logic [7:0] port;
  logic drv, wr_s, rd_s, sda_line;
  int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0, hi_moves = 0;
  logic drv_prev = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~drv;

  i2c_port_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .pin_i(pins), .port_o(port), .sda_drive_low_o(drv),
    .wr_strobe_o(wr_s), .rd_strobe_o(rd_s));

  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (wr_s) wr_cnt++;
      if (rd_s) rd_cnt++;
      if (drv != drv_prev && scl) hi_moves++;
    end
    drv_prev = drv;
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic bus_stop();
    sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(2*Q);
  endtask
  task automatic send_bit(logic b);
    sda_m = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
  endtask
  task automatic recv_bit(output logic b);
    sda_m = 1; tick(Q); scl = 1; tick(Q); b = sda_line; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic send_byte(logic [7:0] v, output logic ack_n);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(ack_n);
  endtask
  task automatic recv_byte(logic master_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(!master_ack);
  endtask

  task automatic t_reset();
    chk(port == 8'hFF, "R1 port", port, 8'hFF);
    chk(drv == 1'b0, "R1 sda", drv, 0);
    chk(!wr_s && !rd_s, "R1 strobes", {wr_s, rd_s}, 0);
  endtask

  task automatic t_write_single();
    logic a;
    bus_start();
    send_byte(8'h4A, a); chk(a == 0, "R2 addr ack", a, 0);
    send_byte(8'hA3, a); chk(a == 0, "R4 data ack", a, 0);
    chk(port == 8'hA3, "R4 port", port, 8'hA3);
    chk(wr_cnt == 1, "R12 wr strobes", wr_cnt, 1);
    bus_stop();
  endtask

  task automatic t_multi();
    logic a;
    logic [7:0] vals [3] = '{8'h11, 8'h22, 8'h5C};
    bus_start();
    send_byte(8'h4A, a);
    foreach (vals[i]) begin
      send_byte(vals[i], a);
      chk(port == vals[i], "R5 overwrite", port, vals[i]);
    end
    chk(wr_cnt == 4, "R5 strobe count", wr_cnt, 4);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte(8'h4C, a); chk(a == 1, "R3 no ack strap", a, 1);
    send_byte(8'h00, a); chk(a == 1, "R3 data ignored", a, 1);
    chk(port == 8'h5C, "R3 port kept", port, 8'h5C);
    bus_stop();
    bus_start();
    send_byte(8'h7A, a); chk(a == 1, "R2 other prefix", a, 1);
    bus_stop();
    chk(wr_cnt == 4, "R3 no strobe", wr_cnt, 4);
  endtask

  task automatic t_read();
    logic a, b;
    logic [7:0] v;
    pins = 8'h96;
    bus_start();
    send_byte(8'h4B, a); chk(a == 0, "R2 read ack", a, 0);
    pins = 8'h3C;
    recv_byte(1'b1, v); chk(v == 8'h96, "R6 R8 first byte", v, 8'h96);
    pins = 8'hE1;
    recv_byte(1'b0, v); chk(v == 8'h3C, "R7 second byte", v, 8'h3C);
    recv_bit(b); chk(b == 1, "R7 released after nack", b, 1);
    chk(drv == 0, "R7 drive off", drv, 0);
    bus_stop();
    chk(rd_cnt == 2, "R12 rd strobes", rd_cnt, 2);
  endtask

  task automatic t_stop_mid();
    logic a;
    bus_start();
    send_byte(8'h4A, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    chk(port == 8'h5C, "R9 partial dropped", port, 8'h5C);
    chk(wr_cnt == 4, "R9 no strobe", wr_cnt, 4);
  endtask

  task automatic t_restart();
    logic a;
    logic [7:0] v;
    pins = 8'h0F;
    bus_start();
    send_byte(8'h4A, a);
    send_byte(8'h81, a);
    bus_start();
    send_byte(8'h4B, a); chk(a == 0, "R10 readdress ack", a, 0);
    recv_byte(1'b0, v); chk(v == 8'h0F, "R10 read after restart", v, 8'h0F);
    bus_stop();
    chk(port == 8'h81, "R10 port held", port, 8'h81);
  endtask

  initial begin
    tick(4); rst = 0; tick(2);
    t_reset();
    t_write_single();
    t_multi();
    t_mismatch();
    t_read();
    t_stop_mid();
    t_restart();
    chk(hi_moves == 0, "R11 sda while scl high", hi_moves, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule